// File: doc/BRIEF.md
# Firmware Configuration Blob Port

This block is a slave register window through which boot firmware fetches configuration blobs from a small on-chip store. The firmware writes a 16-bit key into a selector register. That picks a blob and rewinds a byte cursor to the blob's first byte. The firmware then reads the blob through a 64-bit data register, which behaves as a byte stream. Each access moves the cursor forward by as many bytes as the access is wide. A wide access returns consecutive stream bytes, with the earliest byte in the lowest byte lane.

The store holds three blobs. A fixed four-byte signature lets the firmware confirm that the port is present. A four-byte revision word tells it which protocol revision it is talking to. A writable scratch blob can be filled through the same data register, and the bytes land at the cursor position. Reads past the end of a blob return zeros, and so do reads of keys that are not in the store. Writes that cannot land anywhere are dropped.

The bus is a simple synchronous request port. Each request carries an address, a write flag, a size code and write data. Read data comes back one cycle after the request, qualified by `rsp_valid`.

The control logic is a two-state machine:
- `S_IDLE` is the state when no read result is presented.
- `S_RESP` is the state in the cycle after a read has been accepted.

It has four transitions:
- `S_IDLE` to `S_RESP` on any read request.
- `S_RESP` to `S_RESP` on a further read request.
- `S_RESP` to `S_IDLE` when no read request is present.
- `S_IDLE` to `S_IDLE` when no read request is present.

Top module: `cfg_blob_port`

## Requirements
- R1: The data register is at byte offset 0x0. The selector is written only by a 2-byte write (size code 1) at offset 0x8; any other write at a nonzero offset is ignored. A read at any offset other than 0x0, the selector offsets included, returns all-zero data.
- R2: The selector key is big-endian on the bus. `req_wdata[7:0]` (the byte at offset 0x8) is the key's high byte and `req_wdata[15:8]` (offset 0x9) is its low byte.
- R3: A selector write sets the byte cursor to 0.
- R4: The size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Each read or write at offset 0x0 advances the cursor by that count, whatever blob is selected. The cursor saturates at its maximum value.
- R5: In a data read, byte lane k (`rsp_rdata[8k+7:8k]`) holds stream byte cursor+k. Lanes at or above the access width read as zero.
- R6: Key 0x0000 selects a signature blob holding the bytes 0x51, 0x45, 0x4D, 0x55, in stream order.
- R7: Key 0x0001 selects a four-byte revision blob that holds a little-endian 32-bit value. The default value is zero.
- R8: Key 0x0002 selects a writable scratch blob of SCR_BYTES bytes (16 by default). On a data write, lane k is stored at stream position cursor+k, for each lane within the access width.
- R9: A stream byte beyond the end of the selected blob reads as zero, and every byte of an unknown key reads as zero.
- R10: A data write to the signature blob, to the revision blob, to an unknown key, or to a scratch position beyond its end changes no stored byte.
- R11: A data access at offsets 0x1 to 0x7 leaves the cursor and the stored bytes unchanged. A read there returns zero.
- R12: `rsp_valid` is 1 exactly in the cycle after an accepted read request, and `rsp_rdata` carries that read's data in the same cycle. A write produces no response.
- R13: A synchronous reset selects key 0x0000, sets the cursor to 0, clears every scratch byte, drives `rsp_valid` low and drives `rsp_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset within the window |
| req_size | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Write data, byte lane k at offset addr+k |
| rsp_valid | output | 1 | Read data valid (cycle after read request) |
| rsp_rdata | output | 64 | Read data |

## Verification
The signature is read four ways: as a run of single bytes, as 2-byte halves, as one 4-byte word and as one 8-byte read. Matching results show that lane packing and cursor advance agree for every width, and the 8-byte read also exposes any nonzero bytes past the end of the blob. The scratch blob is filled with two 8-byte writes and read back with mixed widths at unaligned cursor positions. This pattern separates a cursor that advances by the access width from one that advances by a fixed amount, and it shows that a single-byte overwrite lands at the current position. The selector is written with swapped key bytes, with a 1-byte write and at a nonzero data offset, which separates big-endian key decode and the rejection of stray accesses from a correct selection.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int LANES  = 8;
    localparam int DATA_W = LANES * 8;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_DATA_RD = 3'd1,
        OP_DATA_WR = 3'd2,
        OP_SEL_WR  = 3'd3,
        OP_ZERO_RD = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        BLOB_NONE = 2'd0,
        BLOB_SIG  = 2'd1,
        BLOB_REV  = 2'd2,
        BLOB_SCR  = 2'd3
    } blob_e;

    // byte i of a word whose first stream byte is its most significant byte
    function automatic logic [7:0] msb_first_byte(input logic [31:0] w, input logic [1:0] i);
        logic [31:0] s;
        s = w << {i, 3'b000};
        return s[31:24];
    endfunction

    // byte i of a word whose first stream byte is its least significant byte
    function automatic logic [7:0] lsb_first_byte(input logic [31:0] w, input logic [1:0] i);
        logic [31:0] s;
        s = w >> {i, 3'b000};
        return s[7:0];
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int KEY_W  = 16
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output op_e               op,
    output logic [3:0]        nbytes
);

    localparam logic [ADDR_W-1:0] DATA_OFS = '0;
    localparam logic [ADDR_W-1:0] SEL_OFS  = ADDR_W'(8);
    localparam logic [1:0]        SEL_SIZE = 2'($clog2(KEY_W / 8));

    always_comb begin
        op = OP_NONE;
        if (req_valid) begin
            if (!req_write) begin
                op = (req_addr == DATA_OFS) ? OP_DATA_RD : OP_ZERO_RD;
            end else if (req_addr == DATA_OFS) begin
                op = OP_DATA_WR;
            end else if (req_addr == SEL_OFS && req_size == SEL_SIZE) begin
                op = OP_SEL_WR;
            end
        end
    end

    always_comb begin
        unique case (size_e'(req_size))
            SZ_1B:   nbytes = 4'd1;
            SZ_2B:   nbytes = 4'd2;
            SZ_4B:   nbytes = 4'd4;
            SZ_8B:   nbytes = 4'd8;
            default: nbytes = 4'd1;
        endcase
    end

endmodule

// File: rtl/cfgp_store.sv
module cfgp_store
    import cfgp_pkg::*;
#(
    parameter int              KEY_W     = 16,
    parameter int              PTR_W     = 16,
    parameter int              SCR_BYTES = 16,
    parameter logic [KEY_W-1:0] KEY_SIG  = 16'h0000,
    parameter logic [KEY_W-1:0] KEY_REV  = 16'h0001,
    parameter logic [KEY_W-1:0] KEY_SCR  = 16'h0002,
    parameter logic [31:0]     SIG_WORD  = 32'h5145_4D55,
    parameter logic [31:0]     REV_WORD  = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [KEY_W-1:0]  key,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [3:0]        nbytes,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_bytes
);

    localparam int             SCR_IW  = (SCR_BYTES > 1) ? $clog2(SCR_BYTES) : 1;
    localparam logic [PTR_W:0] FIX_LEN = (PTR_W+1)'(4);
    localparam logic [PTR_W:0] SCR_LEN = (PTR_W+1)'(SCR_BYTES);

    blob_e      blob;
    logic [7:0] scr_q [SCR_BYTES];

    always_comb begin
        if (key == KEY_SIG)      blob = BLOB_SIG;
        else if (key == KEY_REV) blob = BLOB_REV;
        else if (key == KEY_SCR) blob = BLOB_SCR;
        else                     blob = BLOB_NONE;
    end

    // read path: one byte fetch per lane
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [PTR_W:0] idx;
        logic [7:0]     b;
        assign idx = {1'b0, ptr} + (PTR_W+1)'(k);
        always_comb begin
            b = 8'h00;
            if (4'(k) < nbytes) begin
                unique case (blob)
                    BLOB_SIG:  if (idx < FIX_LEN) b = msb_first_byte(SIG_WORD, idx[1:0]);
                    BLOB_REV:  if (idx < FIX_LEN) b = lsb_first_byte(REV_WORD, idx[1:0]);
                    BLOB_SCR:  if (idx < SCR_LEN) b = scr_q[idx[SCR_IW-1:0]];
                    BLOB_NONE: b = 8'h00;
                    default:   b = 8'h00;
                endcase
            end
        end
        assign rd_bytes[8*k +: 8] = b;
    end

    // write path: each scratch byte picks its lane by distance from the cursor
    for (genvar j = 0; j < SCR_BYTES; j++) begin : g_scr
        logic [PTR_W:0]    rel;
        logic              hit;
        logic [DATA_W-1:0] shifted;
        assign rel     = (PTR_W+1)'(j) - {1'b0, ptr};
        assign hit     = wr_en && (blob == BLOB_SCR) && ({1'b0, ptr} <= (PTR_W+1)'(j))
                         && (rel < (PTR_W+1)'(nbytes));
        assign shifted = wdata >> {rel[2:0], 3'b000};
        always_ff @(posedge clk) begin
            if (rst)      scr_q[j] <= 8'h00;
            else if (hit) scr_q[j] <= shifted[7:0];
        end
    end

endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
#(
    parameter int KEY_W = 16,
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [3:0]        nbytes,
    input  logic [KEY_W-1:0]  sel_wdata,
    input  logic [DATA_W-1:0] rd_bytes,
    output logic [KEY_W-1:0]  key_q,
    output logic [PTR_W-1:0]  ptr_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int KEY_BYTES = KEY_W / 8;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } state_e;

    state_e            state_q, state_d;
    logic              is_read;
    logic [KEY_W-1:0]  key_be;
    logic [PTR_W:0]    ptr_sum;
    logic [PTR_W-1:0]  ptr_adv;
    logic [DATA_W-1:0] rdata_q;

    assign is_read = (op == OP_DATA_RD) || (op == OP_ZERO_RD);

    // lowest-addressed bus byte becomes the key's most significant byte
    for (genvar i = 0; i < KEY_BYTES; i++) begin : g_keyswap
        assign key_be[KEY_W-1-8*i -: 8] = sel_wdata[8*i +: 8];
    end

    assign ptr_sum = {1'b0, ptr_q} + (PTR_W+1)'(nbytes);
    assign ptr_adv = ptr_sum[PTR_W] ? '1 : ptr_sum[PTR_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (is_read)  state_d = S_RESP;
            S_RESP:  if (!is_read) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // selector, cursor and read-data registers
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q   <= '0;
            ptr_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (op)
                OP_SEL_WR: begin
                    key_q <= key_be;
                    ptr_q <= '0;
                end
                OP_DATA_RD: begin
                    rdata_q <= rd_bytes;
                    ptr_q   <= ptr_adv;
                end
                OP_DATA_WR: ptr_q   <= ptr_adv;
                OP_ZERO_RD: rdata_q <= '0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_RESP:  rsp_valid = 1'b1;
            default: rsp_valid = 1'b0;
        endcase
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/cfg_blob_port.sv
module cfg_blob_port
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter int              KEY_W     = 16,
    parameter int              PTR_W     = 16,
    parameter int              SCR_BYTES = 16,
    parameter logic [KEY_W-1:0] KEY_SIG  = 16'h0000,
    parameter logic [KEY_W-1:0] KEY_REV  = 16'h0001,
    parameter logic [KEY_W-1:0] KEY_SCR  = 16'h0002,
    parameter logic [31:0]     SIG_WORD  = 32'h5145_4D55,
    parameter logic [31:0]     REV_WORD  = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata
);

    op_e               op;
    logic [3:0]        nbytes;
    logic [KEY_W-1:0]  sel_key;
    logic [PTR_W-1:0]  byte_ptr;
    logic [DATA_W-1:0] rd_bytes;

    cfgp_decode #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .op        (op),
        .nbytes    (nbytes)
    );

    cfgp_store #(
        .KEY_W(KEY_W), .PTR_W(PTR_W), .SCR_BYTES(SCR_BYTES),
        .KEY_SIG(KEY_SIG), .KEY_REV(KEY_REV), .KEY_SCR(KEY_SCR),
        .SIG_WORD(SIG_WORD), .REV_WORD(REV_WORD)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .key      (sel_key),
        .ptr      (byte_ptr),
        .nbytes   (nbytes),
        .wr_en    (op == OP_DATA_WR),
        .wdata    (req_wdata),
        .rd_bytes (rd_bytes)
    );

    cfgp_ctrl #(.KEY_W(KEY_W), .PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .nbytes    (nbytes),
        .sel_wdata (req_wdata[KEY_W-1:0]),
        .rd_bytes  (rd_bytes),
        .key_q     (sel_key),
        .ptr_q     (byte_ptr),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/cfg_blob_port_checker.sv
module cfg_blob_port_checker #(
    parameter int ADDR_W = 4,
    parameter int PTR_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [63:0]       req_wdata,
    input logic              rsp_valid,
    input logic [63:0]       rsp_rdata,
    input logic [15:0]       sel_key,
    input logic [PTR_W-1:0]  byte_ptr
);

    logic             rd_req, sel_wr, data_acc, side_acc;
    logic [PTR_W-1:0] width_bytes;

    assign rd_req      = req_valid && !req_write;
    assign sel_wr      = req_valid && req_write && (req_addr == ADDR_W'(8)) && (req_size == 2'd1);
    assign data_acc    = req_valid && (req_addr == '0);
    assign side_acc    = req_valid && (req_addr != '0) && !sel_wr;
    assign width_bytes = PTR_W'(1) << req_size;

    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);                                                    // R12
    AST_NO_RESP_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid);                                                  // R12
    AST_SEL_CLEARS_PTR: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (byte_ptr == '0));                                             // R3
    AST_SEL_BIG_ENDIAN: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (sel_key == {$past(req_wdata[7:0]), $past(req_wdata[15:8])})); // R2
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (data_acc && byte_ptr < PTR_W'(256)) |=> (byte_ptr == $past(byte_ptr) + $past(width_bytes))); // R4
    AST_OFFSET_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
        side_acc |=> $stable(byte_ptr));                                          // R11
    AST_SIDE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_addr != '0) |=> (rsp_rdata == 64'h0));                     // R1
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_addr == '0 && req_size == 2'd0) |=> (rsp_rdata[63:8] == 56'h0)); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sel_key == 16'h0 && byte_ptr == '0 && !rsp_valid && rsp_rdata == 64'h0)); // R13

endmodule

bind cfg_blob_port cfg_blob_port_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .sel_key   (sel_key),
    .byte_ptr  (byte_ptr)
);

// File: tb/tb_cfg_blob_port.sv
`timescale 1ns/1ps
module tb_cfg_blob_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [63:0] SIG4 = 64'h0000_0000_554D_4551; // bytes 51 45 4D 55 in lanes 0..3

    always #10 clk = ~clk;

    cfg_blob_port dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [3:0] a, input logic [1:0] s,
                          input logic [63:0] d, output logic v, output logic [63:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        v = rsp_valid; r = rsp_rdata;
    endtask

    task automatic select(input logic [15:0] key);
        logic v; logic [63:0] r;
        access(1'b1, 4'h8, 2'd1, {48'h0, key[7:0], key[15:8]}, v, r);
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] r);
        logic v;
        access(1'b0, 4'h0, s, 64'h0, v, r);
    endtask

    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        logic v; logic [63:0] r;
        access(1'b1, 4'h0, s, d, v, r);
    endtask

    task automatic t_reset_state();
        check("R13 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
        check("R13 rsp_rdata after reset", rsp_rdata, 64'h0);
    endtask

    task automatic t_signature_widths();
        logic v; logic [63:0] r;
        access(1'b0, 4'h0, 2'd2, 64'h0, v, r);
        check("R12 valid after read", {63'h0, v}, 64'h1);
        check("R6 R13 signature 4B after reset", r, SIG4);
        select(16'h0000);
        rd(2'd0, r); check("R5 sig byte0", r, 64'h51);
        rd(2'd0, r); check("R4 sig byte1", r, 64'h45);
        rd(2'd0, r); check("R4 sig byte2", r, 64'h4D);
        rd(2'd0, r); check("R6 sig byte3", r, 64'h55);
        rd(2'd0, r); check("R9 past end", r, 64'h0);
        select(16'h0000);
        rd(2'd1, r); check("R5 sig half0", r, 64'h4551);
        rd(2'd1, r); check("R4 sig half1", r, 64'h554D);
        select(16'h0000);
        rd(2'd3, r); check("R9 R5 sig 8B zero tail", r, SIG4);
    endtask

    task automatic t_revision_and_readonly();
        logic [63:0] r;
        select(16'h0001);
        wr(2'd2, 64'hFFFF_FFFF);
        select(16'h0001);
        rd(2'd2, r); check("R7 R10 revision zero", r, 64'h0);
        select(16'h0000);
        wr(2'd2, 64'hFFFF_FFFF);
        select(16'h0000);
        rd(2'd2, r); check("R10 signature unchanged", r, SIG4);
    endtask

    task automatic t_scratch();
        logic v; logic [63:0] r;
        select(16'h0002);
        wr(2'd3, 64'h8877_6655_4433_2211);
        wr(2'd3, 64'h0FED_CBA9_8765_4321);
        wr(2'd0, 64'hAA);                    // beyond end, dropped
        select(16'h0002);
        rd(2'd0, r); check("R8 scratch byte0", r, 64'h11);
        rd(2'd2, r); check("R8 scratch 4B at 1", r, 64'h5544_3322);
        rd(2'd1, r); check("R4 scratch 2B at 5", r, 64'h7766);
        rd(2'd3, r); check("R5 scratch 8B at 7", r, 64'hEDCB_A987_6543_2188);
        rd(2'd1, r); check("R9 R10 scratch tail", r, 64'h000F);
        rd(2'd0, r); check("R9 beyond scratch", r, 64'h0);
        select(16'h0002);
        rd(2'd1, r);
        wr(2'd0, 64'h5A);
        select(16'h0002);
        rd(2'd2, r); check("R8 overwrite at cursor", r, 64'h445A_2211);
        // 1-byte write at selector offset must not select or rewind
        rd(2'd0, r);
        access(1'b1, 4'h8, 2'd0, 64'h0, v, r);
        check("R12 no response to write", {63'h0, v}, 64'h0);
        rd(2'd0, r); check("R1 byte write at 0x8 ignored", r, 64'h66);
    endtask

    task automatic t_selector_and_offsets();
        logic v; logic [63:0] r;
        access(1'b1, 4'h8, 2'd1, 64'h0002, v, r); // key 0x0200
        rd(2'd3, r); check("R2 swapped key unknown", r, 64'h0);
        access(1'b1, 4'h8, 2'd1, 64'h0200, v, r); // key 0x0002
        rd(2'd0, r); check("R2 big-endian key", r, 64'h11);
        select(16'h1234);
        rd(2'd3, r); check("R9 unknown key", r, 64'h0);
        select(16'h0000);
        access(1'b0, 4'h3, 2'd0, 64'h0, v, r);
        check("R11 offset read valid", {63'h0, v}, 64'h1);
        check("R11 offset read zero", r, 64'h0);
        access(1'b1, 4'h5, 2'd0, 64'hFF, v, r);
        rd(2'd0, r); check("R11 cursor held", r, 64'h51);
        access(1'b0, 4'h8, 2'd1, 64'h0, v, r);
        check("R1 selector reads zero", r, 64'h0);
        rd(2'd0, r);
        select(16'h0000);
        rd(2'd0, r); check("R3 reselect rewinds", r, 64'h51);
    endtask

    task automatic t_mid_reset();
        logic [63:0] r;
        select(16'h0002);
        rd(2'd0, r);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R13 valid low after reset", {63'h0, rsp_valid}, 64'h0);
        check("R13 rdata zero after reset", rsp_rdata, 64'h0);
        rd(2'd2, r); check("R13 key and cursor cleared", r, SIG4);
        select(16'h0002);
        rd(2'd3, r); check("R13 scratch cleared", r, 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_signature_widths();
        t_revision_and_readonly();
        t_scratch();
        t_selector_and_offsets();
        t_mid_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule